// File: doc/BRIEF.md
# Per-Pin Drive Waveform Formatter

This block shapes one test-channel pin. Once per tester cycle it captures a single data bit and turns it into a drive waveform, according to the programmed waveform format and edge times. It also emits a one-tick compare strobe at the programmed sampling instant, so that the channel's receiver can check the response of the device being tested. All times are counted in ticks of the block clock. A tester cycle lasts a programmable number of ticks and begins on a cycle-start pulse.

Settings are written through a small register port. They are staged there and copied into the active set at the next cycle start, so reprogramming never disturbs a cycle already in flight. Each timing group also holds two analog-related flags. These are kept only so that software can read them back; threshold control, level control and calibration are done elsewhere.

Tick numbering: when `cycleStart` is high at a rising edge, the clock period right after that edge is tick 0. Each later edge advances the tick by one. The cycle is running while the tick is below the period.

Top module: `pin_wave_former`

## Requirements
- R1: After reset, `driveOut` and `strobeOut` are 0, and every register reads back as 0 (format NRZ, all times 0, flags clear).
- R2: Register map on `cfgAddr`: 0 = mode word, with format in bits [1:0] (0 NRZ, 1 RZ, 2 RO, 3 RC), the variable-threshold flag in bit 2 and the variable-levels flag in bit 3; 1 = delay; 2 = width; 3 = sample; 4 = period. `cfgRdata` returns the staged value of the addressed register at once. The two flags have no effect on `driveOut` or `strobeOut`.
- R3: A register write takes effect only at the next cycle start. A write made during a running cycle does not change that cycle's waveform.
- R4: NRZ: from tick `delay` on, the output shows the cycle's data bit. Before that tick it keeps the last value presented at a delay tick by any earlier cycle. If `delay` is not below `period`, the output keeps that earlier value for the whole cycle.
- R5: RZ: with data 1 the output is high on ticks in [delay, delay+width) and low otherwise. With data 0 it stays low.
- R6: RO: with data 0 the output is low on ticks in [delay, delay+width) and high otherwise. With data 1 it stays high.
- R7: RC: the output is the data bit on ticks in [delay, delay+width) and its complement at all other times.
- R8: `strobeOut` is high for exactly one tick, tick `sample`, and only when `sample` is below `period`.
- R9: The pulse window is cut off at the end of the cycle. Once the tick reaches `period` the window is closed and the output returns to its out-of-window level.
- R10: In NRZ the width setting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write enable |
| cfgAddr | input | 3 | Register index |
| cfgWdata | input | TICK_W | Register write data |
| cfgRdata | output | TICK_W | Staged value of the addressed register |
| cycleStart | input | 1 | Starts a tester cycle at this edge |
| dataBit | input | 1 | Value bit for the cycle, captured with cycleStart |
| driveOut | output | 1 | Formatted drive waveform |
| strobeOut | output | 1 | Compare strobe |

## Verification
The bench targets the places where each format flips its polarity. A design that mixed up RZ and RO would idle at the wrong level outside the window. A design that ignored the complement in RC would stay flat for one data value. The bench programs a window that runs past the period and a sample point at the period. A formatter without truncation would then leave its pulse high after the cycle ends, and a loose strobe compare would fire one tick late. The bench also rewrites the delay in the middle of a cycle and runs NRZ with a delay beyond the period, to catch designs that apply settings early or update the held level at the wrong time.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

  typedef enum logic [1:0] {
    FMT_NRZ = 2'd0,
    FMT_RZ  = 2'd1,
    FMT_RO  = 2'd2,
    FMT_RC  = 2'd3
  } fmt_e;

  localparam int CFG_ADDR_W = 3;
  localparam logic [CFG_ADDR_W-1:0] REG_MODE   = 3'd0;
  localparam logic [CFG_ADDR_W-1:0] REG_DELAY  = 3'd1;
  localparam logic [CFG_ADDR_W-1:0] REG_WIDTH  = 3'd2;
  localparam logic [CFG_ADDR_W-1:0] REG_SAMPLE = 3'd3;
  localparam logic [CFG_ADDR_W-1:0] REG_PERIOD = 3'd4;

  // control -> datapath strobes
  typedef struct packed {
    logic loadCycle;
    logic afterDelay;
    logic inWindow;
    fmt_e fmt;
  } fmt_strobes_t;

endpackage

// File: rtl/pwf_regs.sv
module pwf_regs
  import pwf_pkg::*;
#(
  parameter int TICK_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [TICK_W-1:0]     cfgWdata,
  output logic [TICK_W-1:0]     cfgRdata,
  output fmt_e                  stgFmt,
  output logic [TICK_W-1:0]     stgDelay,
  output logic [TICK_W-1:0]     stgWidth,
  output logic [TICK_W-1:0]     stgSample,
  output logic [TICK_W-1:0]     stgPeriod
);

  localparam int MODE_PAD = TICK_W - 4;

  logic varThresh;
  logic varLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgFmt    <= FMT_NRZ;
      varThresh <= 1'b0;
      varLevel  <= 1'b0;
      stgDelay  <= '0;
      stgWidth  <= '0;
      stgSample <= '0;
      stgPeriod <= '0;
    end else if (cfgWe) begin
      case (cfgAddr)
        REG_MODE: begin
          stgFmt    <= fmt_e'(cfgWdata[1:0]);
          varThresh <= cfgWdata[2];
          varLevel  <= cfgWdata[3];
        end
        REG_DELAY:  stgDelay  <= cfgWdata;
        REG_WIDTH:  stgWidth  <= cfgWdata;
        REG_SAMPLE: stgSample <= cfgWdata;
        REG_PERIOD: stgPeriod <= cfgWdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfgAddr)
      REG_MODE:   cfgRdata = {{MODE_PAD{1'b0}}, varLevel, varThresh, stgFmt};
      REG_DELAY:  cfgRdata = stgDelay;
      REG_WIDTH:  cfgRdata = stgWidth;
      REG_SAMPLE: cfgRdata = stgSample;
      REG_PERIOD: cfgRdata = stgPeriod;
      default:    cfgRdata = '0;
    endcase
  end

endmodule

// File: rtl/pwf_ctrl.sv
module pwf_ctrl
  import pwf_pkg::*;
#(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStart,
  input  fmt_e              stgFmt,
  input  logic [TICK_W-1:0] stgDelay,
  input  logic [TICK_W-1:0] stgWidth,
  input  logic [TICK_W-1:0] stgSample,
  input  logic [TICK_W-1:0] stgPeriod,
  output fmt_strobes_t      strobes,
  output logic              strobeOut
);

  localparam int SUM_W = TICK_W + 1;

  fmt_e              actFmt;
  logic [TICK_W-1:0] actDelay;
  logic [TICK_W-1:0] actWidth;
  logic [TICK_W-1:0] actSample;
  logic [TICK_W-1:0] actPeriod;
  logic [TICK_W-1:0] tick;
  logic              running;
  logic [SUM_W-1:0]  winEnd;
  logic              lastTick;

  assign lastTick = (tick == actPeriod - TICK_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actFmt    <= FMT_NRZ;
      actDelay  <= '0;
      actWidth  <= '0;
      actSample <= '0;
      actPeriod <= '0;
      tick      <= '0;
      running   <= 1'b0;
    end else if (cycleStart) begin
      actFmt    <= stgFmt;
      actDelay  <= stgDelay;
      actWidth  <= stgWidth;
      actSample <= stgSample;
      actPeriod <= stgPeriod;
      tick      <= '0;
      running   <= (stgPeriod != '0);
    end else if (running) begin
      if (lastTick) running <= 1'b0;
      else          tick    <= tick + TICK_W'(1);
    end
  end

  // window end kept one bit wider so delay+width never wraps
  assign winEnd = {1'b0, actDelay} + {1'b0, actWidth};

  always_comb begin
    strobes.loadCycle  = cycleStart;
    strobes.fmt        = actFmt;
    strobes.afterDelay = running && (tick >= actDelay);
    strobes.inWindow   = strobes.afterDelay && ({1'b0, tick} < winEnd);
  end

  assign strobeOut = running && (tick == actSample);

  AST_TICK_IN_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (tick < actPeriod)); // R9

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStart |=> ($stable(actDelay) && $stable(actWidth) && $stable(actSample)
                    && $stable(actPeriod) && $stable(actFmt))); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOut && !cycleStart) |=> !strobeOut); // R8

endmodule

// File: rtl/pwf_datapath.sv
module pwf_datapath
  import pwf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  fmt_strobes_t strobes,
  input  logic         dataBit,
  output logic         driveOut
);

  logic capVal;
  logic nrzLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capVal   <= 1'b0;
      nrzLevel <= 1'b0;
    end else begin
      if (strobes.afterDelay) nrzLevel <= capVal;
      if (strobes.loadCycle)  capVal   <= dataBit;
    end
  end

  always_comb begin
    case (strobes.fmt)
      FMT_NRZ: driveOut = strobes.afterDelay ? capVal : nrzLevel;
      FMT_RZ:  driveOut = strobes.inWindow & capVal;
      FMT_RO:  driveOut = capVal | ~strobes.inWindow;
      FMT_RC:  driveOut = strobes.inWindow ? capVal : ~capVal;
      default: driveOut = 1'b0;
    endcase
  end

  AST_NRZ_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fmt == FMT_NRZ && strobes.afterDelay && !strobes.loadCycle)
      |=> $stable(driveOut)); // R4

  AST_RZ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fmt == FMT_RZ && !strobes.inWindow) |-> !driveOut); // R5

  AST_RO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fmt == FMT_RO && !strobes.inWindow) |-> driveOut); // R6

endmodule

// File: rtl/pin_wave_former.sv
module pin_wave_former
  import pwf_pkg::*;
#(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [TICK_W-1:0] cfgWdata,
  output logic [TICK_W-1:0] cfgRdata,
  input  logic              cycleStart,
  input  logic              dataBit,
  output logic              driveOut,
  output logic              strobeOut
);

  fmt_e              stgFmt;
  logic [TICK_W-1:0] stgDelay;
  logic [TICK_W-1:0] stgWidth;
  logic [TICK_W-1:0] stgSample;
  logic [TICK_W-1:0] stgPeriod;
  fmt_strobes_t      strobes;

  pwf_regs #(.TICK_W(TICK_W)) regs_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .stgFmt(stgFmt),
    .stgDelay(stgDelay), .stgWidth(stgWidth), .stgSample(stgSample),
    .stgPeriod(stgPeriod)
  );

  pwf_ctrl #(.TICK_W(TICK_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .stgFmt(stgFmt),
    .stgDelay(stgDelay), .stgWidth(stgWidth), .stgSample(stgSample),
    .stgPeriod(stgPeriod), .strobes(strobes), .strobeOut(strobeOut)
  );

  pwf_datapath datapath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataBit(dataBit),
    .driveOut(driveOut)
  );

endmodule

// File: tb/pin_wave_former_tb_top.sv
`timescale 1ns/1ps
module pin_wave_former_tb_top;

  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [2:0]    cfgAddr = '0;
  logic [TW-1:0] cfgWdata = '0;
  logic [TW-1:0] cfgRdata;
  logic          cycleStart = 1'b0;
  logic          dataBit = 1'b0;
  logic          driveOut;
  logic          strobeOut;

  int nCompared = 0;
  int nMismatched = 0;
  bit finished = 0;
  logic heldModel = 1'b0;

  typedef struct {
    logic  expDrive;
    logic  expStrobe;
    string tag;
  } exp_item_t;

  exp_item_t scoreQ[$];

  always #2 clk = ~clk;

  pin_wave_former #(.TICK_W(TW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .cycleStart(cycleStart),
    .dataBit(dataBit), .driveOut(driveOut), .strobeOut(strobeOut)
  );

  task automatic chk(string tag, logic [TW-1:0] act, logic [TW-1:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: one expected item per tick, popped away from the active edge
  always @(negedge clk) begin
    if (scoreQ.size() > 0) begin
      exp_item_t it;
      it = scoreQ.pop_front();
      chk({it.tag, " drive"}, TW'(driveOut), TW'(it.expDrive));
      chk({it.tag, " strobe"}, TW'(strobeOut), TW'(it.expStrobe));
    end
  end

  task automatic cfgWrite(logic [2:0] a, logic [TW-1:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // fmt: 0 NRZ, 1 RZ, 2 RO, 3 RC
  task automatic runCycle(string tag, int fmt, int flags, int d, int w, int s,
                          int p, logic v, int midDelay);
    logic heldBefore;
    cfgWrite(3'd0, TW'((flags << 2) | fmt));
    cfgWrite(3'd1, TW'(d));
    cfgWrite(3'd2, TW'(w));
    cfgWrite(3'd3, TW'(s));
    cfgWrite(3'd4, TW'(p));
    @(negedge clk);
    cycleStart = 1'b1; dataBit = v;
    @(posedge clk);
    #1 cycleStart = 1'b0; dataBit = ~v;
    heldBefore = heldModel;
    for (int k = 0; k < p + 2; k++) begin
      exp_item_t it;
      logic inW;
      logic drv;
      inW = (k < p) && (k >= d) && (k < d + w);
      case (fmt)
        0: drv = (k >= d && d < p) ? v : heldBefore;
        1: drv = inW & v;
        2: drv = v | ~inW;
        default: drv = inW ? v : ~v;
      endcase
      it.expDrive = drv;
      it.expStrobe = (k < p) && (k == s);
      it.tag = tag;
      scoreQ.push_back(it);
    end
    if (d < p) heldModel = v;
    if (midDelay >= 0) cfgWrite(3'd1, TW'(midDelay));
    wait (scoreQ.size() == 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 drive", TW'(driveOut), '0);
    chk("R1 strobe", TW'(strobeOut), '0);
    for (int a = 0; a < 5; a++) begin
      cfgAddr = 3'(a);
      #0.5;
      chk("R1 readback", cfgRdata, '0);
    end
    rstN = 1'b1;

    // R2: register readback, flags stored
    cfgWrite(3'd0, 8'h0E);
    chk("R2 mode", cfgRdata, 8'h0E);
    cfgWrite(3'd1, 8'h5A);
    chk("R2 delay", cfgRdata, 8'h5A);
    cfgWrite(3'd2, 8'h33);
    chk("R2 width", cfgRdata, 8'h33);
    cfgWrite(3'd3, 8'hC1);
    chk("R2 sample", cfgRdata, 8'hC1);
    cfgWrite(3'd4, 8'h7F);
    chk("R2 period", cfgRdata, 8'h7F);

    // R4 / R10: NRZ with non-zero width
    runCycle("R4 R10 nrz v1", 0, 0, 2, 5, 3, 8, 1'b1, -1);
    runCycle("R4 nrz v0",     0, 0, 3, 1, 0, 7, 1'b0, -1);
    runCycle("R4 nrz v1 d0",  0, 0, 0, 0, 5, 6, 1'b1, -1);
    // R4: delay beyond period keeps earlier value
    runCycle("R4 nrz late",   0, 0, 9, 0, 2, 6, 1'b0, -1);
    // R5: RZ
    runCycle("R5 rz v1", 1, 0, 1, 3, 7, 8, 1'b1, -1);
    runCycle("R5 rz v0", 1, 0, 1, 3, 2, 8, 1'b0, -1);
    // R6: RO
    runCycle("R6 ro v0", 2, 0, 2, 2, 4, 7, 1'b0, -1);
    runCycle("R6 ro v1", 2, 0, 2, 2, 4, 7, 1'b1, -1);
    // R7: RC
    runCycle("R7 rc v1", 3, 0, 0, 4, 1, 6, 1'b1, -1);
    runCycle("R7 rc v0", 3, 0, 3, 2, 5, 8, 1'b0, -1);
    // R9 / R8: window past the end, sample equal to period (no strobe)
    runCycle("R9 R8 rz trunc", 1, 0, 5, 10, 8, 8, 1'b1, -1);
    runCycle("R8 last tick",   3, 0, 2, 1, 5, 6, 1'b1, -1);
    // R3: mid-cycle write does not disturb the running cycle
    runCycle("R3 mid write",   0, 0, 2, 0, 1, 8, 1'b0, 6);
    chk("R3 staged delay", cfgRdata, 8'd6);
    runCycle("R3 next cycle",  0, 0, 6, 0, 1, 8, 1'b1, -1);
    // R2: flags set, waveform unchanged
    runCycle("R2 flags rz",    1, 3, 1, 2, 3, 6, 1'b1, -1);
    runCycle("R2 flags nrz",   0, 3, 4, 0, 0, 6, 1'b0, -1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

endmodule